// File: doc/BRIEF.md
# Flash Power-Up Command Gate

This block sits in the command front end of a serial flash device, between the opcode decoder and the execution logic. It decides, for every decoded instruction, whether the device is allowed to act on it yet. A power-good input from the on-chip voltage monitor acts as the block's reset. While it is low, nothing is taken and the downstream status state is held at its start-up values. Once it rises, two cycle counters stage the enable. Read-class instructions open first, after a short select delay that runs while the supply-in-range input is high. Write-class instructions stay refused until a longer, separate inhibit delay has also run out.

Each opcode strobe taken while chip select is low gives exactly one response, one cycle later: an accept pulse or a reject pulse. Strobes with chip select high are not taken. The block also drives the values that the status logic loads while it is held in reset: the write-enable latch, the write-in-progress flag, the lock bit pair and the power mode.

Top module: `flash_pwrup_gate`

## Requirements
- R1: While `pwr_good_i` is low, `accept_o` and `reject_o` stay low for any input, and `hold_rst_o` is high. While it is high, `hold_rst_o` is low.
- R2: A read-class opcode strobed with chip select low is accepted only if `pwr_good_i` and `vcc_ok_i` have both been high for at least `RD_DLY` clock edges before the strobe cycle. Otherwise it is rejected.
- R3: A write-class opcode is rejected unless `pwr_good_i` has been high for at least `WI_DLY` clock edges before the strobe cycle.
- R4: A write-class opcode is accepted only when the R3 delay has run out and the R2 read-select condition is also met.
- R5: With default parameters, the write-class set is exactly 06h, 02h, A2h, 42h, 20h, D8h, C7h, 01h and E5h. Every other 8-bit opcode is read-class.
- R6: A strobe with `cs_n_i` high produces neither an accept pulse nor a reject pulse.
- R7: Each strobe taken with `cs_n_i` low and `pwr_good_i` high gives exactly one of `accept_o` or `reject_o`, high for one cycle, in the cycle after the strobe.
- R8: If `pwr_good_i` falls in the strobe cycle or in the response cycle, no accept or reject pulse is seen for that command.
- R9: The start-up values are driven as: write-enable latch 0, write-in-progress 0, lock pair (write lock, lock down) = 2'b00, and `standby_init_o` = 1 (standby mode, not deep power-down).
- R10: The read-select count restarts from zero whenever `vcc_ok_i` or `pwr_good_i` goes low. The inhibit count restarts whenever `pwr_good_i` goes low. Both counts saturate at their terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| pwr_good_i | input | 1 | Power-good from the voltage monitor; low holds the block in reset |
| vcc_ok_i | input | 1 | Supply is at or above its minimum operating level |
| cs_n_i | input | 1 | Chip select, active low |
| op_valid_i | input | 1 | One-cycle strobe for a decoded opcode |
| op_code_i | input | 8 | Decoded opcode |
| accept_o | output | 1 | One-cycle pulse: the opcode may execute |
| reject_o | output | 1 | One-cycle pulse: the opcode is ignored |
| hold_rst_o | output | 1 | High while the status logic must hold its start-up values |
| wel_init_o | output | 1 | Start-up value of the write-enable latch |
| wip_init_o | output | 1 | Start-up value of the write-in-progress flag |
| lock_init_o | output | 2 | Start-up lock pair {write lock, lock down} |
| standby_init_o | output | 1 | Start-up power mode, 1 = standby |

## Verification
A select count that is off by one shows up in the first strobe at the window edge. A read or write issued exactly `RD_DLY` or `WI_DLY` edges after the qualifying rise flips from reject to accept, so the sweeps strobe at every offset around both limits. An error in the opcode classification shows on the first strobe of the wrong opcode. The sweep therefore walks all 256 codes while only the read window is open. A counter that fails to restart, or a pending response that survives a power-good drop, shows as a stray pulse within one or two cycles of the drop or supply glitch.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    localparam int unsigned OP_W    = 8;
    localparam int unsigned N_WR_OP = 9;

    typedef logic [N_WR_OP-1:0][OP_W-1:0] wr_op_list_t;

    localparam wr_op_list_t WR_OPS_DEFAULT = {
        8'hE5, 8'h01, 8'hC7, 8'hD8, 8'h20, 8'h42, 8'hA2, 8'h02, 8'h06
    };

    typedef struct packed {
        logic acc;
        logic rej;
    } resp_t;

endpackage

// File: rtl/fpg_delay_timer.sv
module fpg_delay_timer #(
    parameter int unsigned DLY = 16
) (
    input  logic clk_i,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = (DLY < 1) ? 1 : $clog2(DLY + 1);
    localparam logic [CW-1:0] TERM = CW'(DLY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q != TERM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign done_o = run_i && (cnt_q == TERM);

    p_cnt_sat_r10: assert property (@(posedge clk_i) disable iff (!run_i)
        cnt_q <= TERM);

    p_restart_r10: assert property (@(posedge clk_i)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/fpg_op_class.sv
module fpg_op_class
    import fpg_pkg::*;
#(
    parameter wr_op_list_t WR_OPS = WR_OPS_DEFAULT
) (
    input  logic [OP_W-1:0] op_code_i,
    output logic            is_write_o
);
    logic [N_WR_OP-1:0] hit;

    for (genvar g = 0; g < N_WR_OP; g++) begin : g_match
        assign hit[g] = (op_code_i == WR_OPS[g]);
    end

    assign is_write_o = |hit;

endmodule

// File: rtl/flash_pwrup_gate.sv
module flash_pwrup_gate
    import fpg_pkg::*;
#(
    parameter int unsigned RD_DLY = 5,
    parameter int unsigned WI_DLY = 12,
    parameter wr_op_list_t WR_OPS = WR_OPS_DEFAULT
) (
    input  logic            clk_i,
    input  logic            pwr_good_i,
    input  logic            vcc_ok_i,
    input  logic            cs_n_i,
    input  logic            op_valid_i,
    input  logic [OP_W-1:0] op_code_i,
    output logic            accept_o,
    output logic            reject_o,
    output logic            hold_rst_o,
    output logic            wel_init_o,
    output logic            wip_init_o,
    output logic [1:0]      lock_init_o,
    output logic            standby_init_o
);
    logic rd_run, rd_done, wi_done, wr_open, is_wr, take;
    resp_t resp_d, resp_q;

    assign rd_run = pwr_good_i && vcc_ok_i;

    fpg_delay_timer #(.DLY(RD_DLY)) u_rd_timer (
        .clk_i  (clk_i),
        .run_i  (rd_run),
        .done_o (rd_done)
    );

    fpg_delay_timer #(.DLY(WI_DLY)) u_wi_timer (
        .clk_i  (clk_i),
        .run_i  (pwr_good_i),
        .done_o (wi_done)
    );

    fpg_op_class #(.WR_OPS(WR_OPS)) u_class (
        .op_code_i  (op_code_i),
        .is_write_o (is_wr)
    );

    assign wr_open = wi_done && rd_done;
    assign take    = pwr_good_i && op_valid_i && !cs_n_i;

    always_comb begin
        resp_d = '0;
        if (take) begin
            if (is_wr ? wr_open : rd_done) begin
                resp_d.acc = 1'b1;
            end else begin
                resp_d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        resp_q <= resp_d;
    end

    assign accept_o       = resp_q.acc && pwr_good_i;
    assign reject_o       = resp_q.rej && pwr_good_i;
    assign hold_rst_o     = !pwr_good_i;
    assign wel_init_o     = 1'b0;
    assign wip_init_o     = 1'b0;
    assign lock_init_o    = 2'b00;
    assign standby_init_o = 1'b1;

    p_silent_r1: assert property (@(posedge clk_i)
        !pwr_good_i |-> !(accept_o || reject_o));

    p_one_resp_r7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !(accept_o && reject_o));

    p_cs_gate_r6: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (accept_o || reject_o) |-> $past(op_valid_i && !cs_n_i));

    p_wr_inhibit_r3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (accept_o && $past(is_wr)) |-> $past(wi_done));

    p_rd_select_r2: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        accept_o |-> $past(rd_done));

endmodule

// File: tb/flash_pwrup_gate_tb_top.sv
`timescale 1ns/1ps
module flash_pwrup_gate_tb_top;

    localparam int RD = 5;
    localparam int WI = 12;

    logic       clk = 1'b0;
    logic       pg = 1'b0;
    logic       vcc = 1'b0;
    logic       cs_n = 1'b1;
    logic       ov = 1'b0;
    logic [7:0] op = 8'h00;
    logic       acc, rej, hold, wel, wip, stby;
    logic [1:0] lck;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    flash_pwrup_gate #(.RD_DLY(RD), .WI_DLY(WI)) dut_i (
        .clk_i(clk), .pwr_good_i(pg), .vcc_ok_i(vcc), .cs_n_i(cs_n),
        .op_valid_i(ov), .op_code_i(op), .accept_o(acc), .reject_o(rej),
        .hold_rst_o(hold), .wel_init_o(wel), .wip_init_o(wip),
        .lock_init_o(lck), .standby_init_o(stby)
    );

    function automatic bit ref_is_wr(input logic [7:0] c);
        case (c)
            8'h06, 8'h02, 8'hA2, 8'h42, 8'h20,
            8'hD8, 8'hC7, 8'h01, 8'hE5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drop power-good for two cycles, then raise it; returns at the raise negedge.
    task automatic repower(input logic v);
        @(negedge clk);
        pg = 1'b0; vcc = v; cs_n = 1'b1; ov = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 hold/silent", {hold, acc, rej, 1'b0}, 4'b1000);
        chk("R9 init values", {wel, wip, lck}, 4'b0000);
        chk("R9 standby", {3'b0, stby}, 4'b0001);
        pg = 1'b1;
    endtask

    // Strobe at the current negedge, check the response one cycle later and its end.
    task automatic do_op(input logic [7:0] c, input logic csn,
                         input logic ea, input logic er, input string tag);
        op = c; cs_n = csn; ov = 1'b1;
        @(negedge clk);
        ov = 1'b0; cs_n = 1'b1;
        chk(tag, {2'b0, acc, rej}, {2'b0, ea, er});
        @(negedge clk);
        chk("R7 single-cycle pulse", {2'b0, acc, rej}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {hold, acc, rej, 1'b0}, 4'b1000);

        // R2: read window sweep
        for (int n = 0; n <= RD + 2; n++) begin
            repower(1'b1);
            repeat (n) @(negedge clk);
            do_op(8'h03, 1'b0, n >= RD, n < RD, "R2 read delay");
        end

        // R3/R4: write window sweep over rotating write opcodes
        for (int n = 0; n <= WI + 2; n++) begin
            logic [7:0] wc;
            case (n % 3)
                0: wc = 8'h06;
                1: wc = 8'hD8;
                default: wc = 8'h01;
            endcase
            repower(1'b1);
            repeat (n) @(negedge clk);
            do_op(wc, 1'b0, n >= WI, n < WI, "R3 write inhibit");
        end

        // R5: all opcodes, read window open, write still inhibited
        for (int c = 0; c < 256; c++) begin
            repower(1'b1);
            repeat (RD) @(negedge clk);
            do_op(c[7:0], 1'b0, !ref_is_wr(c[7:0]), ref_is_wr(c[7:0]), "R5 class (read open)");
        end

        // R5: all opcodes, both windows open
        repower(1'b1);
        repeat (WI) @(negedge clk);
        for (int c = 0; c < 256; c++) begin
            do_op(c[7:0], 1'b0, 1'b1, 1'b0, "R5 class (all open)");
        end

        // R6: chip select high
        do_op(8'h03, 1'b1, 1'b0, 1'b0, "R6 cs high read");
        do_op(8'h06, 1'b1, 1'b0, 1'b0, "R6 cs high write");

        // R4: supply late, inhibit already over
        repower(1'b0);
        repeat (WI + 2) @(negedge clk);
        do_op(8'h02, 1'b0, 1'b0, 1'b1, "R4 write, supply low");
        do_op(8'h0B, 1'b0, 1'b0, 1'b1, "R4 read, supply low");
        vcc = 1'b1;
        repeat (RD - 1) @(negedge clk);
        do_op(8'h02, 1'b0, 1'b0, 1'b1, "R4 write, select pending");
        do_op(8'h02, 1'b0, 1'b1, 1'b0, "R4 write, both open");

        // R10: one-cycle supply glitch restarts the read count
        vcc = 1'b0;
        @(negedge clk);
        vcc = 1'b1;
        do_op(8'h03, 1'b0, 1'b0, 1'b1, "R10 read after glitch");
        do_op(8'h20, 1'b0, 1'b0, 1'b1, "R10 write after glitch");
        repeat (RD) @(negedge clk);
        do_op(8'h03, 1'b0, 1'b1, 1'b0, "R10 read reopened");

        // R1: strobes while power-good low
        @(negedge clk);
        pg = 1'b0;
        do_op(8'h03, 1'b0, 1'b0, 1'b0, "R1 read, power low");
        do_op(8'h06, 1'b0, 1'b0, 1'b0, "R1 write, power low");
        chk("R1 hold high", {3'b0, hold}, 4'b0001);

        // R8: power-good falls in the strobe cycle
        repower(1'b1);
        repeat (WI) @(negedge clk);
        op = 8'h03; cs_n = 1'b0; ov = 1'b1; pg = 1'b0;
        @(negedge clk);
        ov = 1'b0; cs_n = 1'b1; pg = 1'b1;
        chk("R8 drop in strobe cycle", {2'b0, acc, rej}, 4'b0000);

        // R8: power-good falls in the response cycle
        repower(1'b1);
        repeat (WI) @(negedge clk);
        op = 8'h06; cs_n = 1'b0; ov = 1'b1;
        @(negedge clk);
        ov = 1'b0; cs_n = 1'b1; pg = 1'b0;
        #1;
        chk("R8 drop in response cycle", {2'b0, acc, rej}, 4'b0000);
        @(negedge clk);
        pg = 1'b1;
        @(negedge clk);
        chk("R8 no late pulse", {2'b0, acc, rej}, 4'b0000);
        do_op(8'h03, 1'b0, 1'b0, 1'b1, "R8 restart closed");

        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule